// File: doc/BRIEF.md
# Paged Program Counter Sequencer

This block sequences instruction fetch for a small processor core. It keeps a 13-bit program counter and drives it out as the fetch address. On each clock it takes one of several actions. It can advance to the next address. It can take a computed write of the low byte. It can jump or call to an 11-bit target carried in the opcode. It can return from a subroutine, or branch to the interrupt vector. The decoder, ALU, program memory and interrupt arbiter sit outside the block and send only strobes and data.

The upper five address bits are never written directly. They come from a separate 5-bit holding latch. A computed low-byte write copies all five latch bits into the top of the counter. A jump or call uses only the latch's two top bits as a page select above the 11-bit target. Return addresses go into an 8-entry hardware stack that software cannot address. The stack wraps around with no overflow or underflow indication.

Top module: `prog_seq`

## Requirements
- R1: While rst_ni is low, and after it rises, pc_o is 0000h and hold_o is 00h until the first action.
- R2: An advance strobe alone loads pc_o+1 on the next edge, and 1FFFh advances to 0000h.
- R3: A low-byte write loads {hold_o[4:0], pcl_wdata_i} on the next edge. The latch value used is the one held before any latch write in the same cycle.
- R4: A jump loads {hold_o[4:3], tgt_i[10:0]}, using the latch value held before the edge.
- R5: A call loads the same page-plus-target address as a jump and pushes pc_o+1 onto the stack.
- R6: An interrupt pushes pc_o+1 and loads 0004h.
- R7: A return pops the most recently pushed, not yet popped, 13-bit value into pc_o.
- R8: The stack holds 8 entries and is circular. The ninth push overwrites the first, and so on. A pop from an empty stack returns the entry the wrapped pointer selects, which is 0000h for a stack untouched since reset.
- R9: hold_o changes only on a latch write, where it takes hold_wdata_i on the next edge. Pushes and pops leave it unchanged.
- R10: When several action strobes are high, only the highest one takes effect. The order, highest first, is interrupt, return, call, jump, low-byte write, advance. With no action strobe, pc_o holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| adv_i | input | 1 | Advance to next sequential address |
| pcl_we_i | input | 1 | Computed write of the low byte |
| pcl_wdata_i | input | 8 | ALU result for the low byte |
| jump_i | input | 1 | Jump to opcode target |
| call_i | input | 1 | Call to opcode target |
| tgt_i | input | 11 | Opcode target field |
| ret_i | input | 1 | Return (any return form) |
| irq_i | input | 1 | Interrupt branch |
| hold_we_i | input | 1 | Upper-address latch write |
| hold_wdata_i | input | 5 | Upper-address latch data |
| pc_o | output | 13 | Fetch address |
| hold_o | output | 5 | Upper-address latch value |

## Verification
A latch write can arrive in the same cycle as a low-byte write, jump or call that reads the latch. An interrupt or return can also coincide with a lower-priority action. The bench forces these overlaps both deliberately and through random strobe mixes. A behavioural model applies old-latch-value semantics and the priority order, and it is compared with pc_o and hold_o after every edge. Nine calls followed by nine returns show the overwrite of the oldest entry.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;
  typedef enum logic [2:0] {
    SRC_HOLD,
    SRC_INC,
    SRC_LOW,
    SRC_JUMP,
    SRC_CALL,
    SRC_RET,
    SRC_IRQ
  } pc_src_e;
endpackage

// File: rtl/prog_seq_stack.sv
module prog_seq_stack #(
  parameter int unsigned W     = 13,
  parameter int unsigned DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] push_data_i,
  output logic [W-1:0] top_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [PW-1:0] sp_q;
  logic [PW-1:0] sp_inc, sp_dec;
  logic [W-1:0]  mem [DEPTH];

  assign sp_inc = (sp_q == LAST) ? '0 : sp_q + 1'b1;
  assign sp_dec = (sp_q == '0) ? LAST : sp_q - 1'b1;
  assign top_o  = mem[sp_dec];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sp_q <= '0;
    else if (push_i) sp_q <= sp_inc;
    else if (pop_i)  sp_q <= sp_dec;
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            mem[e] <= '0;
      else if (push_i && sp_q == PW'(e))      mem[e] <= push_data_i;
    end
  end
endmodule

// File: rtl/prog_seq_next.sv
module prog_seq_next
  import prog_seq_pkg::*;
#(
  parameter int unsigned PC_W  = 13,
  parameter int unsigned LO_W  = 8,
  parameter int unsigned TGT_W = 11,
  parameter logic [PC_W-1:0] IRQ_VEC = 13'h0004
) (
  input  logic                   adv_i,
  input  logic                   pcl_we_i,
  input  logic [LO_W-1:0]        pcl_wdata_i,
  input  logic                   jump_i,
  input  logic                   call_i,
  input  logic [TGT_W-1:0]       tgt_i,
  input  logic                   ret_i,
  input  logic                   irq_i,
  input  logic [PC_W-1:0]        pc_i,
  input  logic [PC_W-LO_W-1:0]   hold_i,
  input  logic [PC_W-1:0]        top_i,
  output logic [PC_W-1:0]        pc_nxt_o,
  output logic                   push_o,
  output logic                   pop_o,
  output logic [PC_W-1:0]        push_data_o
);
  localparam int unsigned HI_W = PC_W - LO_W;
  localparam int unsigned PG_W = PC_W - TGT_W;

  pc_src_e         src;
  logic [PC_W-1:0] seq_addr;
  logic [PC_W-1:0] page_addr;

  assign seq_addr  = pc_i + 1'b1;
  assign page_addr = {hold_i[HI_W-1 -: PG_W], tgt_i};

  always_comb begin
    if      (irq_i)    src = SRC_IRQ;
    else if (ret_i)    src = SRC_RET;
    else if (call_i)   src = SRC_CALL;
    else if (jump_i)   src = SRC_JUMP;
    else if (pcl_we_i) src = SRC_LOW;
    else if (adv_i)    src = SRC_INC;
    else               src = SRC_HOLD;
  end

  always_comb begin
    push_o      = 1'b0;
    pop_o       = 1'b0;
    push_data_o = seq_addr;
    unique case (src)
      SRC_IRQ:  begin pc_nxt_o = IRQ_VEC;   push_o = 1'b1; end
      SRC_RET:  begin pc_nxt_o = top_i;     pop_o  = 1'b1; end
      SRC_CALL: begin pc_nxt_o = page_addr; push_o = 1'b1; end
      SRC_JUMP: pc_nxt_o = page_addr;
      SRC_LOW:  pc_nxt_o = {hold_i, pcl_wdata_i};
      SRC_INC:  pc_nxt_o = seq_addr;
      default:  pc_nxt_o = pc_i;
    endcase
  end
endmodule

// File: rtl/prog_seq.sv
module prog_seq #(
  parameter int unsigned PC_W  = 13,
  parameter int unsigned LO_W  = 8,
  parameter int unsigned TGT_W = 11,
  parameter int unsigned DEPTH = 8,
  parameter logic [PC_W-1:0] IRQ_VEC = 13'h0004
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 adv_i,
  input  logic                 pcl_we_i,
  input  logic [LO_W-1:0]      pcl_wdata_i,
  input  logic                 jump_i,
  input  logic                 call_i,
  input  logic [TGT_W-1:0]     tgt_i,
  input  logic                 ret_i,
  input  logic                 irq_i,
  input  logic                 hold_we_i,
  input  logic [PC_W-LO_W-1:0] hold_wdata_i,
  output logic [PC_W-1:0]      pc_o,
  output logic [PC_W-LO_W-1:0] hold_o
);
  localparam int unsigned HI_W = PC_W - LO_W;

  logic [PC_W-1:0] pc_q, pc_nxt, top, push_data;
  logic [HI_W-1:0] hold_q;
  logic            push, pop;

  prog_seq_next #(
    .PC_W(PC_W), .LO_W(LO_W), .TGT_W(TGT_W), .IRQ_VEC(IRQ_VEC)
  ) u_next (
    .adv_i(adv_i), .pcl_we_i(pcl_we_i), .pcl_wdata_i(pcl_wdata_i),
    .jump_i(jump_i), .call_i(call_i), .tgt_i(tgt_i),
    .ret_i(ret_i), .irq_i(irq_i),
    .pc_i(pc_q), .hold_i(hold_q), .top_i(top),
    .pc_nxt_o(pc_nxt), .push_o(push), .pop_o(pop), .push_data_o(push_data)
  );

  prog_seq_stack #(.W(PC_W), .DEPTH(DEPTH)) u_stack (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .push_i(push), .pop_i(pop), .push_data_i(push_data), .top_o(top)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '0;
      hold_q <= '0;
    end else begin
      pc_q <= pc_nxt;
      if (hold_we_i) hold_q <= hold_wdata_i;
    end
  end

  assign pc_o   = pc_q;
  assign hold_o = hold_q;
endmodule

// File: rtl/prog_seq_chk.sv
module prog_seq_chk #(
  parameter int unsigned PC_W  = 13,
  parameter int unsigned LO_W  = 8,
  parameter int unsigned TGT_W = 11,
  parameter logic [PC_W-1:0] IRQ_VEC = 13'h0004
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 adv_i,
  input logic                 pcl_we_i,
  input logic [LO_W-1:0]      pcl_wdata_i,
  input logic                 jump_i,
  input logic                 call_i,
  input logic [TGT_W-1:0]     tgt_i,
  input logic                 ret_i,
  input logic                 irq_i,
  input logic                 hold_we_i,
  input logic [PC_W-LO_W-1:0] hold_wdata_i,
  input logic [PC_W-1:0]      pc_o,
  input logic [PC_W-LO_W-1:0] hold_o
);
  localparam int unsigned HI_W = PC_W - LO_W;
  localparam int unsigned PG_W = PC_W - TGT_W;

  logic any_op;
  assign any_op = adv_i | pcl_we_i | jump_i | call_i | ret_i | irq_i;

  assert_reset_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (pc_o == '0 && hold_o == '0));

  assert_adv_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !pcl_we_i && !jump_i && !call_i && !ret_i && !irq_i)
    |=> pc_o == PC_W'($past(pc_o) + 1'b1));

  assert_low_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pcl_we_i && !jump_i && !call_i && !ret_i && !irq_i)
    |=> pc_o == {$past(hold_o), $past(pcl_wdata_i)});

  assert_jump_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((jump_i || call_i) && !ret_i && !irq_i)
    |=> pc_o == {$past(hold_o[HI_W-1 -: PG_W]), $past(tgt_i)});

  assert_irq_vec_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |=> pc_o == IRQ_VEC);

  assert_hold_keep_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_we_i |=> $stable(hold_o));

  assert_hold_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_we_i |=> hold_o == $past(hold_wdata_i));

  assert_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_op |=> $stable(pc_o));
endmodule

bind prog_seq prog_seq_chk #(
  .PC_W(PC_W), .LO_W(LO_W), .TGT_W(TGT_W), .IRQ_VEC(IRQ_VEC)
) u_chk (.*);

// File: tb/sim_prog_seq.sv
module sim_prog_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        adv_i = 0, pcl_we_i = 0, jump_i = 0, call_i = 0, ret_i = 0, irq_i = 0, hold_we_i = 0;
  logic [7:0]  pcl_wdata_i = 0;
  logic [10:0] tgt_i = 0;
  logic [4:0]  hold_wdata_i = 0;
  logic [12:0] pc_o;
  logic [4:0]  hold_o;

  int tests = 0, fails = 0;
  int m_pc = 0, m_hold = 0, m_sp = 0;
  int m_stk [8];
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  prog_seq u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(adv_i), .pcl_we_i(pcl_we_i),
    .pcl_wdata_i(pcl_wdata_i), .jump_i(jump_i), .call_i(call_i), .tgt_i(tgt_i),
    .ret_i(ret_i), .irq_i(irq_i), .hold_we_i(hold_we_i), .hold_wdata_i(hold_wdata_i),
    .pc_o(pc_o), .hold_o(hold_o)
  );

  task automatic compare(string tag);
    tests++;
    if (int'(pc_o) != m_pc || int'(hold_o) != m_hold) begin
      fails++;
      $display("FAIL %s pc=%h hold=%h expected pc=%h hold=%h", tag, pc_o, hold_o, m_pc[12:0], m_hold[4:0]);
    end
  endtask

  // Drive at a falling edge, advance the model, check at the next falling edge
  task automatic cyc(bit a, bit pw, int wd, bit j, bit c, int t, bit r, bit i,
                     bit hw, int hd, string tag);
    int ra;
    adv_i = a; pcl_we_i = pw; pcl_wdata_i = wd[7:0]; jump_i = j; call_i = c;
    tgt_i = t[10:0]; ret_i = r; irq_i = i; hold_we_i = hw; hold_wdata_i = hd[4:0];
    ra = (m_pc + 1) % 8192;
    if (i) begin
      m_stk[m_sp] = ra; m_sp = (m_sp + 1) % 8; m_pc = 4;
    end else if (r) begin
      m_sp = (m_sp + 7) % 8; m_pc = m_stk[m_sp];
    end else if (c) begin
      m_stk[m_sp] = ra; m_sp = (m_sp + 1) % 8;
      m_pc = (((m_hold >> 3) & 3) << 11) | (t & 2047);
    end else if (j) begin
      m_pc = (((m_hold >> 3) & 3) << 11) | (t & 2047);
    end else if (pw) begin
      m_pc = (m_hold << 8) | (wd & 255);
    end else if (a) begin
      m_pc = ra;
    end
    if (hw) m_hold = hd & 31;
    @(negedge clk_i);
    compare(tag);
  endtask

  task automatic idle(string tag);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    for (int k = 0; k < 8; k++) m_stk[k] = 0;
    repeat (3) @(negedge clk_i);
    compare("R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare("R1 after reset");
    // R8: pop from empty stack after reset gives 0000h
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R8 empty pop");
    repeat (4) cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 advance");
    idle("R10 idle hold");
    // R2 wrap from 1FFFh
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 31, "R9 latch write");
    cyc(0, 1, 255, 0, 0, 0, 0, 0, 0, 0, "R3 low write full latch");
    cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 wrap to zero");
    // R3 same-cycle latch write uses old latch
    cyc(0, 1, 8'h3c, 0, 0, 0, 0, 0, 1, 5'h06, "R3 old latch value");
    cyc(0, 1, 8'h11, 0, 0, 0, 0, 0, 0, 0, "R3 new latch value");
    // R4 jump uses latch bits 4:3 only
    cyc(0, 0, 0, 1, 0, 11'h555, 0, 0, 1, 5'h18, "R4 jump old page");
    cyc(0, 0, 0, 1, 0, 11'h2aa, 0, 0, 0, 0, "R4 jump page 3");
    // R5 call and R7 return
    cyc(0, 0, 0, 0, 1, 11'h123, 0, 0, 0, 0, "R5 call");
    cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 inside sub");
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R7 return");
    // R6 interrupt, R9 latch untouched by push/pop
    cyc(1, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R6 irq over advance");
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R9 pop keeps latch");
    // R8 nine calls then nine returns
    for (int k = 0; k < 9; k++) cyc(0, 0, 0, 0, 1, 16 * k + 1, 0, 0, 0, 0, "R8 push");
    for (int k = 0; k < 9; k++) cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R8 pop wrapped");
    // R10 priority combinations
    cyc(1, 1, 8'h77, 1, 1, 11'h0f0, 1, 1, 0, 0, "R10 irq wins");
    cyc(1, 1, 8'h77, 1, 1, 11'h0f0, 1, 0, 0, 0, "R10 ret wins");
    cyc(1, 1, 8'h77, 1, 1, 11'h0f0, 0, 0, 0, 0, "R10 call wins");
    cyc(1, 1, 8'h77, 1, 0, 11'h0f0, 0, 0, 0, 0, "R10 jump wins");
    cyc(1, 1, 8'h77, 0, 0, 0, 0, 0, 0, 0, "R10 low write wins");
    // Random mixes of strobes
    for (int n = 0; n < 3000; n++) begin
      automatic int u = int'($urandom_range(0, 99));
      cyc(u < 60, ($urandom_range(0, 9) == 0), int'($urandom_range(0, 255)),
          ($urandom_range(0, 11) == 0), ($urandom_range(0, 9) == 0),
          int'($urandom_range(0, 2047)), ($urandom_range(0, 9) == 0),
          ($urandom_range(0, 29) == 0), ($urandom_range(0, 7) == 0),
          int'($urandom_range(0, 31)), "R10 random mix");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog R10 expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule